// File: doc/BRIEF.md
# Segmented Program Counter Unit

This block owns the 22-bit code address of a 16-bit processor core. The address is split across two architectural registers. The 16-bit program counter (`pc_q`) supplies address bits 15:0. The low six bits of the 16-bit status register (`sr_q`) supply bits 21:16, which form the code segment. The upper ten status bits are condition flags. Other logic writes those flags, and this block keeps them intact whenever it rewrites the address.

A sequencer drives a 3-bit command on each clock. The block supports these commands:
- opcode fetch and extension-word consumption, each of which advances the address by one;
- relative branch by a signed magnitude;
- far jump;
- far call;
- restore to the start-of-instruction address;
- direct load of a full address.

The elaboration parameter `CORE_VER` selects the address arithmetic. Values below 11 keep every add inside the 16-bit program counter. Values of 11 and above add across all 22 bits, so carries and borrows reach the segment.

A far call takes three cycles and is controlled by a small state machine with three states:
- `ST_IDLE` accepts commands. On `CMD_FARCALL` it advances the address past the extension word and moves to `ST_PUSH_PC`.
- `ST_PUSH_PC` presents the program counter as the first stack word and moves to `ST_PUSH_SR`.
- `ST_PUSH_SR` presents the status register as the second stack word, loads the call target, and returns to `ST_IDLE`.

All other commands finish in `ST_IDLE` in one cycle. The stack pointer itself belongs to the sequencer.

Top module: `seg_pc_unit`

## Requirements
- R1: `fetch_addr` equals `{sr_q[5:0], pc_q}` at all times.
  - While reset is held, the address takes the value of `RST_ADDR` (default 0) and `sr_q[15:6]` is 0.
- R2: Command encodings are NONE=0, FETCH=1, EXT=2, BRANCH=3, FARJMP=4, FARCALL=5, RESTORE=6, SET=7.
  - A FETCH or EXT accepted while idle advances the address by one, visible after the next rising edge.
- R3: With `CORE_VER` < 11, every add (FETCH, EXT, BRANCH, and the far-call advance) wraps modulo 2^16 inside `pc_q` and leaves the segment unchanged.
- R4: With `CORE_VER` >= 11, every add works on the whole 22-bit address, so carry and borrow propagate into the segment. The sum wraps modulo 2^22.
- R5: BRANCH adds `br_off` (unsigned magnitude) when `br_neg` is 0 and subtracts it when `br_neg` is 1, using the rule of R3 or R4.
- R6: FARJMP sets the address to `{far_seg, far_word}` in one cycle and produces no stack word.
- R7: A FARCALL behaves as follows:
  - On acceptance it advances the address by one.
  - The next cycle shows `push_valid`=1, `push_is_sr`=0, and `push_data` equal to the advanced `pc_q`.
  - The cycle after that shows `push_valid`=1, `push_is_sr`=1, and `push_data` equal to `sr_q`.
  - After that, the address is `{far_seg, far_word}` as captured at acceptance. `busy` is 1 during both push cycles.
- R8: Any command presented while `busy` is 1 is ignored.
- R9: FETCH records the address it starts from. RESTORE returns the whole 22-bit address to that recorded value.
- R10: SET loads `set_addr` into the full 22-bit address in one cycle.
- R11: Address writes never change `sr_q[15:6]`. Asserting `flags_we` replaces `sr_q[15:6]` with `flags_in` and leaves the segment and `pc_q` untouched, including in the same cycle as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Sequencer command (encodings in R2) |
| br_off | input | OFF_W | Branch offset magnitude |
| br_neg | input | 1 | Branch direction, 1 = backward |
| far_seg | input | 6 | Target segment for far jump or call |
| far_word | input | 16 | Target low word for far jump or call |
| set_addr | input | 22 | Address for direct load |
| flags_we | input | 1 | Write enable for status bits 15:6 |
| flags_in | input | 10 | New value for status bits 15:6 |
| fetch_addr | output | 22 | Current code address |
| pc_q | output | 16 | Program counter register |
| sr_q | output | 16 | Status register |
| busy | output | 1 | Far-call push sequence in progress |
| push_valid | output | 1 | A stack word is presented this cycle |
| push_is_sr | output | 1 | 0 = program counter word, 1 = status word |
| push_data | output | 16 | Stack word to store |

## Verification
Two instances, one for each value of `CORE_VER`, receive identical stimulus so that each difference in expected results isolates the version rule. Several patterns are used:
- Increments from a low address with no carry show that plain stepping works in both versions.
- Increments from xx_FFFF and from 3F_FFFF separate a 16-bit wrap from segment carry and from the modulo-2^22 rollover.
- A backward branch from a low offset exposes borrow handling.
- A far call from 07_FFFF makes the pushed status word differ between versions, which checks both push order and the carry behaviour of the advance.
- Commands issued during the push cycles, and flag writes that coincide with address writes, show what is ignored and what is kept.

// File: rtl/seg_pc_pkg.sv
package seg_pc_pkg;

    localparam int PC_W   = 16;
    localparam int SEG_W  = 6;
    localparam int SR_W   = 16;
    localparam int ADDR_W = PC_W + SEG_W;
    localparam int FLG_W  = SR_W - SEG_W;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_FETCH   = 3'd1,
        CMD_EXT     = 3'd2,
        CMD_BRANCH  = 3'd3,
        CMD_FARJMP  = 3'd4,
        CMD_FARCALL = 3'd5,
        CMD_RESTORE = 3'd6,
        CMD_SET     = 3'd7
    } pc_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_PC = 2'd1,
        ST_PUSH_SR = 2'd2
    } pc_state_e;

    typedef enum logic [1:0] {
        WSEL_HOLD = 2'd0,
        WSEL_SUM  = 2'd1,
        WSEL_TGT  = 2'd2,
        WSEL_SNAP = 2'd3
    } wr_sel_e;

endpackage

// File: rtl/seg_pc_adder.sv
module seg_pc_adder
    import seg_pc_pkg::*;
#(
    parameter int CORE_VER = 11,
    parameter int DW       = 7
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic signed [DW-1:0] delta_i,
    output logic [ADDR_W-1:0]    sum_o
);

    generate
        if (CORE_VER >= 11) begin : g_full_width
            // Carry and borrow travel into the segment; result is mod 2^ADDR_W.
            logic [ADDR_W-1:0] ext;
            assign ext   = {{(ADDR_W-DW){delta_i[DW-1]}}, delta_i};
            assign sum_o = addr_i + ext;
        end else begin : g_pc_only
            // Segment is passed through; only the low word moves.
            logic [PC_W-1:0] ext;
            logic [PC_W-1:0] low;
            assign ext   = {{(PC_W-DW){delta_i[DW-1]}}, delta_i};
            assign low   = addr_i[PC_W-1:0] + ext;
            assign sum_o = {addr_i[ADDR_W-1:PC_W], low};
        end
    endgenerate

endmodule

// File: rtl/seg_pc_regs.sv
module seg_pc_regs
    import seg_pc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              flags_we_i,
    input  logic [FLG_W-1:0]  flags_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [SR_W-1:0]   sr_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_o <= RST_ADDR[PC_W-1:0];
            sr_o <= {{FLG_W{1'b0}}, RST_ADDR[ADDR_W-1:PC_W]};
        end else begin
            if (wr_en_i) begin
                pc_o             <= wr_addr_i[PC_W-1:0];
                sr_o[SEG_W-1:0]  <= wr_addr_i[ADDR_W-1:PC_W];
            end
            if (flags_we_i) begin
                sr_o[SR_W-1:SEG_W] <= flags_i;
            end
        end
    end

endmodule

// File: rtl/seg_pc_ctrl.sv
module seg_pc_ctrl
    import seg_pc_pkg::*;
#(
    parameter int                OFF_W    = 6,
    parameter int                DW       = OFF_W + 1,
    parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_i,
    input  logic [OFF_W-1:0]     br_off_i,
    input  logic                 br_neg_i,
    input  logic [SEG_W-1:0]     far_seg_i,
    input  logic [PC_W-1:0]      far_word_i,
    input  logic [ADDR_W-1:0]    set_addr_i,
    input  logic [ADDR_W-1:0]    cur_addr_i,
    input  logic [ADDR_W-1:0]    sum_i,
    output logic signed [DW-1:0] delta_o,
    output logic                 wr_en_o,
    output logic [ADDR_W-1:0]    wr_addr_o,
    output logic                 busy_o,
    output logic                 push_valid_o,
    output logic                 push_is_sr_o
);

    pc_state_e         state_q, state_d;
    pc_cmd_e           cmd;
    logic [ADDR_W-1:0] snap_q;
    logic [ADDR_W-1:0] tgt_q;
    logic              snap_we;
    logic              tgt_we;
    logic              ld_direct;
    wr_sel_e           wsel;
    logic signed [DW-1:0] mag;

    assign cmd = pc_cmd_e'(cmd_i);
    assign mag = {1'b0, br_off_i};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cmd == CMD_FARCALL) state_d = ST_PUSH_PC;
            ST_PUSH_PC: state_d = ST_PUSH_SR;
            ST_PUSH_SR: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        delta_o      = '0;
        wsel         = WSEL_HOLD;
        ld_direct    = 1'b0;
        snap_we      = 1'b0;
        tgt_we       = 1'b0;
        busy_o       = 1'b0;
        push_valid_o = 1'b0;
        push_is_sr_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                unique case (cmd)
                    CMD_NONE: ;
                    CMD_FETCH: begin
                        delta_o = {{(DW-1){1'b0}}, 1'b1};
                        wsel    = WSEL_SUM;
                        snap_we = 1'b1;
                    end
                    CMD_EXT: begin
                        delta_o = {{(DW-1){1'b0}}, 1'b1};
                        wsel    = WSEL_SUM;
                    end
                    CMD_BRANCH: begin
                        delta_o = br_neg_i ? -mag : mag;
                        wsel    = WSEL_SUM;
                    end
                    CMD_FARJMP: begin
                        ld_direct = 1'b1;
                    end
                    CMD_FARCALL: begin
                        delta_o = {{(DW-1){1'b0}}, 1'b1};
                        wsel    = WSEL_SUM;
                        tgt_we  = 1'b1;
                    end
                    CMD_RESTORE: begin
                        wsel = WSEL_SNAP;
                    end
                    CMD_SET: begin
                        ld_direct = 1'b1;
                    end
                    default: ;
                endcase
            end
            ST_PUSH_PC: begin
                busy_o       = 1'b1;
                push_valid_o = 1'b1;
            end
            ST_PUSH_SR: begin
                busy_o       = 1'b1;
                push_valid_o = 1'b1;
                push_is_sr_o = 1'b1;
                wsel         = WSEL_TGT;
            end
            default: ;
        endcase
    end

    // Address write mux
    always_comb begin
        wr_en_o   = 1'b1;
        wr_addr_o = cur_addr_i;
        if (ld_direct) begin
            wr_addr_o = (cmd == CMD_SET) ? set_addr_i : {far_seg_i, far_word_i};
        end else begin
            unique case (wsel)
                WSEL_HOLD: wr_en_o   = 1'b0;
                WSEL_SUM:  wr_addr_o = sum_i;
                WSEL_TGT:  wr_addr_o = tgt_q;
                WSEL_SNAP: wr_addr_o = snap_q;
                default:   wr_en_o   = 1'b0;
            endcase
        end
    end

    // Start-of-instruction snapshot and call target capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= RST_ADDR;
            tgt_q  <= '0;
        end else begin
            if (snap_we) snap_q <= cur_addr_i;
            if (tgt_we)  tgt_q  <= {far_seg_i, far_word_i};
        end
    end

endmodule

// File: rtl/seg_pc_unit.sv
module seg_pc_unit
    import seg_pc_pkg::*;
#(
    parameter int                CORE_VER = 11,
    parameter int                OFF_W    = 6,
    parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          cmd,
    input  logic [OFF_W-1:0]    br_off,
    input  logic                br_neg,
    input  logic [SEG_W-1:0]    far_seg,
    input  logic [PC_W-1:0]     far_word,
    input  logic [ADDR_W-1:0]   set_addr,
    input  logic                flags_we,
    input  logic [FLG_W-1:0]    flags_in,
    output logic [ADDR_W-1:0]   fetch_addr,
    output logic [PC_W-1:0]     pc_q,
    output logic [SR_W-1:0]     sr_q,
    output logic                busy,
    output logic                push_valid,
    output logic                push_is_sr,
    output logic [PC_W-1:0]     push_data
);

    localparam int DW = OFF_W + 1;

    logic signed [DW-1:0] delta;
    logic [ADDR_W-1:0]    sum;
    logic                 wr_en;
    logic [ADDR_W-1:0]    wr_addr;

    assign fetch_addr = {sr_q[SEG_W-1:0], pc_q};
    assign push_data  = push_is_sr ? sr_q : pc_q;

    seg_pc_adder #(
        .CORE_VER (CORE_VER),
        .DW       (DW)
    ) u_adder (
        .addr_i  (fetch_addr),
        .delta_i (delta),
        .sum_o   (sum)
    );

    seg_pc_ctrl #(
        .OFF_W    (OFF_W),
        .DW       (DW),
        .RST_ADDR (RST_ADDR)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_i        (cmd),
        .br_off_i     (br_off),
        .br_neg_i     (br_neg),
        .far_seg_i    (far_seg),
        .far_word_i   (far_word),
        .set_addr_i   (set_addr),
        .cur_addr_i   (fetch_addr),
        .sum_i        (sum),
        .delta_o      (delta),
        .wr_en_o      (wr_en),
        .wr_addr_o    (wr_addr),
        .busy_o       (busy),
        .push_valid_o (push_valid),
        .push_is_sr_o (push_is_sr)
    );

    seg_pc_regs #(
        .RST_ADDR (RST_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .flags_we_i (flags_we),
        .flags_i    (flags_in),
        .pc_o       (pc_q),
        .sr_o       (sr_q)
    );

endmodule

// File: rtl/seg_pc_unit_chk.sv
module seg_pc_unit_chk
    import seg_pc_pkg::*;
#(
    parameter int CORE_VER = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cmd,
    input logic [SEG_W-1:0]  far_seg,
    input logic [PC_W-1:0]   far_word,
    input logic              flags_we,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [SR_W-1:0]   sr_q,
    input logic              busy,
    input logic              push_valid,
    input logic              push_is_sr
);

    logic step_cmd;
    assign step_cmd = !busy && (cmd == CMD_FETCH || cmd == CMD_EXT);

    AST_STEP_LOW_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        step_cmd |=> fetch_addr[PC_W-1:0] == $past(fetch_addr[PC_W-1:0]) + 16'd1); // R2

    generate
        if (CORE_VER < 11) begin : g_v10
            AST_SEG_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
                (step_cmd || (!busy && cmd == CMD_BRANCH))
                |=> $stable(fetch_addr[ADDR_W-1:PC_W])); // R3
        end else begin : g_v11
            AST_FULL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
                step_cmd |=> fetch_addr == $past(fetch_addr) + 22'd1); // R4
        end
    endgenerate

    AST_JUMP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd == CMD_FARJMP)
        |=> !push_valid && fetch_addr == {$past(far_seg), $past(far_word)}); // R6

    AST_CALL_FIRST_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd == CMD_FARCALL) |=> push_valid && !push_is_sr && busy); // R7

    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_is_sr) |=> push_valid && push_is_sr); // R7

    AST_BUSY_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_is_sr) |=> $stable(fetch_addr)); // R8

    AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_we |=> $stable(sr_q[SR_W-1:SEG_W])); // R11

endmodule

bind seg_pc_unit seg_pc_unit_chk #(.CORE_VER(CORE_VER)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .far_seg    (far_seg),
    .far_word   (far_word),
    .flags_we   (flags_we),
    .fetch_addr (fetch_addr),
    .sr_q       (sr_q),
    .busy       (busy),
    .push_valid (push_valid),
    .push_is_sr (push_is_sr)
);

// File: tb/test_seg_pc_unit.sv
`timescale 1ns/1ps
module test_seg_pc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cmd = 3'd0;
    logic [5:0]  br_off = '0;
    logic        br_neg = 1'b0;
    logic [5:0]  far_seg = '0;
    logic [15:0] far_word = '0;
    logic [21:0] set_addr = '0;
    logic        flags_we = 1'b0;
    logic [9:0]  flags_in = '0;

    logic [21:0] fa_a, fa_b;
    logic [15:0] pc_a, pc_b, sr_a, sr_b, pd_a, pd_b;
    logic        busy_a, busy_b, pv_a, pv_b, ps_a, ps_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // Core 1.1 behaviour
    seg_pc_unit #(.CORE_VER(11)) i_seg_pc_unit (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .br_off(br_off), .br_neg(br_neg),
        .far_seg(far_seg), .far_word(far_word), .set_addr(set_addr),
        .flags_we(flags_we), .flags_in(flags_in),
        .fetch_addr(fa_b), .pc_q(pc_b), .sr_q(sr_b), .busy(busy_b),
        .push_valid(pv_b), .push_is_sr(ps_b), .push_data(pd_b));

    // Core 1.0 behaviour
    seg_pc_unit #(.CORE_VER(10)) i_seg_pc_unit_v10 (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .br_off(br_off), .br_neg(br_neg),
        .far_seg(far_seg), .far_word(far_word), .set_addr(set_addr),
        .flags_we(flags_we), .flags_in(flags_in),
        .fetch_addr(fa_a), .pc_q(pc_a), .sr_q(sr_a), .busy(busy_a),
        .push_valid(pv_a), .push_is_sr(ps_a), .push_data(pd_a));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_addr(input string tag, input logic [21:0] e10, input logic [21:0] e11);
        chk({tag, " v10 addr"}, {10'd0, fa_a}, {10'd0, e10});
        chk({tag, " v11 addr"}, {10'd0, fa_b}, {10'd0, e11});
    endtask

    // Advance to the next falling edge, then return inputs to idle.
    task automatic tick();
        @(negedge clk);
        cmd      = 3'd0;
        flags_we = 1'b0;
    endtask

    task automatic do_set(input logic [21:0] a);
        cmd = 3'd7; set_addr = a;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 reset v10", {10'd0, fa_a}, 32'd0);
        chk("R1 reset v11", {10'd0, fa_b}, 32'd0);
        chk("R1 reset sr", {sr_a, sr_b}, 32'd0);
        chk("R7 reset busy", {30'd0, busy_a, busy_b}, 32'd0);
    endtask

    task automatic t_set();
        do_set(22'h2A_1234);
        chk_addr("R10 set", 22'h2A_1234, 22'h2A_1234);
        chk("R1 pc/sr split", {pc_b, sr_b}, {16'h1234, 16'h002A});
    endtask

    task automatic t_step();
        do_set(22'h01_0100);
        cmd = 3'd1; tick();
        chk_addr("R2 fetch", 22'h01_0101, 22'h01_0101);
        cmd = 3'd2; tick();
        chk_addr("R2 ext", 22'h01_0102, 22'h01_0102);
        tick();
        chk_addr("R2 none holds", 22'h01_0102, 22'h01_0102);
    endtask

    task automatic t_wrap();
        do_set(22'h03_FFFF);
        cmd = 3'd2; tick();
        chk_addr("R3 R4 ext carry", 22'h03_0000, 22'h04_0000);
        do_set(22'h3F_FFFF);
        cmd = 3'd1; tick();
        chk_addr("R4 mod 2^22", 22'h3F_0000, 22'h00_0000);
        do_set(22'h05_0002);
        cmd = 3'd3; br_off = 6'd5; br_neg = 1'b1; tick();
        chk_addr("R3 R4 R5 borrow", 22'h05_FFFD, 22'h04_FFFD);
    endtask

    task automatic t_branch();
        do_set(22'h10_0100);
        cmd = 3'd3; br_off = 6'h1F; br_neg = 1'b0; tick();
        chk_addr("R5 forward", 22'h10_011F, 22'h10_011F);
        cmd = 3'd3; br_off = 6'h3F; br_neg = 1'b1; tick();
        chk_addr("R5 backward", 22'h10_00E0, 22'h10_00E0);
    endtask

    task automatic t_flags();
        cmd = 3'd7; set_addr = 22'h2A_1234; flags_we = 1'b1; flags_in = 10'h3C3; tick();
        chk("R11 flags with set", {sr_a, sr_b}, {16'hF0EA, 16'hF0EA});
        do_set(22'h11_0000);
        chk("R11 set keeps flags", {sr_a, sr_b}, {16'hF0D1, 16'hF0D1});
        flags_we = 1'b1; flags_in = 10'h001; tick();
        chk("R11 flags only", {sr_a, sr_b}, {16'h0051, 16'h0051});
        chk_addr("R11 addr untouched", 22'h11_0000, 22'h11_0000);
    endtask

    task automatic t_farjmp();
        cmd = 3'd4; far_seg = 6'h15; far_word = 16'hBEEF; tick();
        chk_addr("R6 far jump", 22'h15_BEEF, 22'h15_BEEF);
        chk("R6 no push", {30'd0, pv_a, pv_b}, 32'd0);
    endtask

    task automatic t_farcall();
        cmd = 3'd7; set_addr = 22'h07_FFFF; flags_we = 1'b1; flags_in = 10'h155; tick();
        cmd = 3'd5; far_seg = 6'h22; far_word = 16'h1357; tick();
        chk("R7 first push valid/kind", {28'd0, pv_a, ps_a, pv_b, ps_b}, 32'b1010);
        chk("R7 first push pc", {pd_a, pd_b}, 32'h0000_0000);
        chk("R7 busy", {30'd0, busy_a, busy_b}, 32'b11);
        // Commands during the push cycles must have no effect.
        cmd = 3'd1; far_seg = 6'h01; far_word = 16'h0001; tick();
        chk("R7 second push kind", {28'd0, pv_a, ps_a, pv_b, ps_b}, 32'b1111);
        chk("R7 second push sr", {pd_a, pd_b}, {16'h5547, 16'h5548});
        chk_addr("R8 held during push", 22'h07_0000, 22'h08_0000);
        cmd = 3'd7; set_addr = 22'h3A_AAAA; tick();
        chk_addr("R7 R8 call target", 22'h22_1357, 22'h22_1357);
        chk("R7 done", {28'd0, busy_a, pv_a, busy_b, pv_b}, 32'd0);
        chk("R11 flags after call", {sr_a, sr_b}, {16'h5562, 16'h5562});
    endtask

    task automatic t_restore();
        do_set(22'h01_0010);
        cmd = 3'd1; tick();
        cmd = 3'd2; tick();
        cmd = 3'd2; tick();
        chk_addr("R9 before restore", 22'h01_0013, 22'h01_0013);
        cmd = 3'd6; tick();
        chk_addr("R9 restore", 22'h01_0010, 22'h01_0010);
        do_set(22'h02_FFFF);
        cmd = 3'd1; tick();
        chk_addr("R9 R3 R4 wrap fetch", 22'h02_0000, 22'h03_0000);
        cmd = 3'd6; tick();
        chk_addr("R9 restore segment", 22'h02_FFFF, 22'h02_FFFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_set();
        t_step();
        t_wrap();
        t_branch();
        t_flags();
        t_farjmp();
        t_farcall();
        t_restore();
        finish_run();
    end

endmodule